// File: doc/BRIEF.md
# Flash Protected Range Checker

This block holds a small bank of protected-range registers for a flash controller and checks every flash access against them. Each 32-bit range register describes a span of flash in 4 KiB pages: a base page, an inclusive limit page, a read-protect enable and a write-protect enable. A register that holds all zeros is treated as an unused slot.

Software reaches the registers through a plain register port: one write per cycle and a combinational read. The lookup port takes a byte address and an access kind (erase is presented as a write) and answers allow or deny combinationally in the same cycle. It is always ready, so a lookup never stalls and never applies back-pressure. A qualifier input marks the cycles that carry a lookup.

An allocate command takes a start address, a byte size and the wanted protections. It encodes them into the lowest-numbered free slot and reports the result one cycle later: a done pulse, a success flag and the slot index. A lock input freezes the whole bank until reset.

Top module: `fprot_range_guard`

## Requirements
- R1: After reset every range register reads zero, alloc_done is low, and every lookup is allowed.
- R2: A register write stores its 32-bit value, which reads back unchanged. The field layout is base page in bits 14:0, read-protect in bit 15, limit page in bits 30:16 and write-protect in bit 31. A write or read with an index of 5 or more has no effect, and such a read returns zero.
- R3: An address matches a range when it is at least base×4096 and at most limit×4096+4095. Both ends are inclusive.
- R4: A read lookup (lk_is_write=0) is denied if a matching range has read-protect set. A write or erase lookup (lk_is_write=1) is denied if a matching range has write-protect set. A protection bit of the other kind does not deny.
- R5: With overlapping ranges, a lookup is denied if any matching range denies it. An address that matches no protecting range is allowed.
- R6: The lookup answer appears in the same cycle as lk_valid. While lk_valid is low, both lk_allow and lk_deny are low.
- R7: An allocate request writes base = start>>12, limit = (start+size−1)>>12 and the requested protect bits into the lowest-numbered zero register. In the next cycle alloc_done pulses with alloc_ok=1 and alloc_slot set to that index.
- R8: When no register is zero, an allocate reports alloc_done=1 with alloc_ok=0 and changes no register.
- R9: An allocate that requests neither protection reports failure and writes nothing.
- R10: Once lock_in is seen high (including the same cycle), register writes and allocates have no effect until reset, and allocates report failure. Lookups keep working.
- R11: When a register write and an allocate arrive in the same cycle, the register write takes effect and the allocate reports failure without writing.
- R12: Writing zero to a register frees it, and a later allocate reuses it when it is the lowest free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Freeze request, sticky until reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register write index |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_idx | input | 3 | Register read index |
| reg_rd_data | output | 32 | Register read value (combinational) |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_addr | input | 27 | Lookup byte address |
| lk_is_write | input | 1 | 1 = write or erase, 0 = read |
| lk_allow | output | 1 | Lookup allowed |
| lk_deny | output | 1 | Lookup denied |
| alloc_req | input | 1 | Allocate command strobe |
| alloc_start | input | 27 | Allocate start byte address |
| alloc_size | input | 28 | Allocate size in bytes, nonzero |
| alloc_rd_prot | input | 1 | Request read protection |
| alloc_wr_prot | input | 1 | Request write protection |
| alloc_done | output | 1 | Allocate result valid, one-cycle pulse |
| alloc_ok | output | 1 | Allocate succeeded |
| alloc_slot | output | 3 | Slot written on success, zero otherwise |

## Verification
The assertions assume that alloc_size is nonzero and that start plus size stays inside the 27-bit flash space, so the limit page never wraps below the base. They also assume that lookup inputs are held steady across the cycle in which lk_valid is sampled. The stimulus changes every input shortly after a rising edge and uses only in-range allocation requests. Out-of-range indices are exercised only on the register port, where they are defined to be ignored.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  localparam int FIELD_W    = 15;
  localparam int GRAN_SHIFT = 12;
  localparam int REG_W      = 2 * FIELD_W + 2;
  localparam int FLASH_AW   = FIELD_W + GRAN_SHIFT;

  typedef logic [FIELD_W-1:0] page_t;

  // Field order from MSB down matches the register bit layout.
  typedef struct packed {
    logic  wr_en;
    page_t limit;
    logic  rd_en;
    page_t base;
  } range_t;
endpackage

// File: rtl/fprot_range_match.sv
module fprot_range_match
  import fprot_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input  range_t [NUM_SLOTS-1:0] slots,
  input  logic [FLASH_AW-1:0]    addr,
  output logic [NUM_SLOTS-1:0]   hit,
  output logic                   rd_block,
  output logic                   wr_block
);
  logic [NUM_SLOTS-1:0] rd_vec;
  logic [NUM_SLOTS-1:0] wr_vec;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign hit[g] = (addr >= {slots[g].base, {GRAN_SHIFT{1'b0}}}) &&
                    (addr <= {slots[g].limit, {GRAN_SHIFT{1'b1}}});
    assign rd_vec[g] = slots[g].rd_en;
    assign wr_vec[g] = slots[g].wr_en;
  end

  assign rd_block = |(hit & rd_vec);
  assign wr_block = |(hit & wr_vec);
endmodule

// File: rtl/fprot_free_pick.sv
module fprot_free_pick
  import fprot_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  range_t [NUM_SLOTS-1:0] slots,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slots[i] == '0) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/fprot_slot_bank.sv
module fprot_slot_bank
  import fprot_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lock_in,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [REG_W-1:0]       wr_data,
  input  logic                   alloc_req,
  input  range_t                 alloc_val,
  input  logic                   free_found,
  input  logic [IDX_W-1:0]       free_idx,
  output range_t [NUM_SLOTS-1:0] slots,
  output logic                   alloc_done,
  output logic                   alloc_ok,
  output logic [IDX_W-1:0]       alloc_slot
);
  localparam logic [IDX_W:0] SLOT_CNT = NUM_SLOTS[IDX_W:0];

  range_t [NUM_SLOTS-1:0] slots_q;
  logic                   lock_q;
  logic                   locked_now;
  logic                   port_wr;
  logic                   alloc_go;

  assign locked_now = lock_q | lock_in;
  assign port_wr    = wr_en && !locked_now && ({1'b0, wr_idx} < SLOT_CNT);
  assign alloc_go   = alloc_req && !locked_now && !wr_en && free_found &&
                      (alloc_val.rd_en || alloc_val.wr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q    <= '0;
      lock_q     <= 1'b0;
      alloc_done <= 1'b0;
      alloc_ok   <= 1'b0;
      alloc_slot <= '0;
    end else begin
      if (lock_in) lock_q <= 1'b1;
      if (port_wr) slots_q[wr_idx] <= range_t'(wr_data);
      else if (alloc_go) slots_q[free_idx] <= alloc_val;
      alloc_done <= alloc_req;
      alloc_ok   <= alloc_go;
      alloc_slot <= alloc_go ? free_idx : '0;
    end
  end

  assign slots = slots_q;

  // R10: a latched lock freezes the bank on every later edge
  assert_locked_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(slots_q));

  // R7: each allocate request is answered one cycle later
  assert_alloc_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> alloc_done);

  // R7: a successful allocate leaves its slot in use
  assert_alloc_target_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_done && alloc_ok) |-> (slots_q[alloc_slot] != '0));
endmodule

// File: rtl/fprot_range_guard.sv
module fprot_range_guard
  import fprot_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_in,
  input  logic                reg_wr_en,
  input  logic [IDX_W-1:0]    reg_wr_idx,
  input  logic [REG_W-1:0]    reg_wr_data,
  input  logic [IDX_W-1:0]    reg_rd_idx,
  output logic [REG_W-1:0]    reg_rd_data,
  input  logic                lk_valid,
  input  logic [FLASH_AW-1:0] lk_addr,
  input  logic                lk_is_write,
  output logic                lk_allow,
  output logic                lk_deny,
  input  logic                alloc_req,
  input  logic [FLASH_AW-1:0] alloc_start,
  input  logic [FLASH_AW:0]   alloc_size,
  input  logic                alloc_rd_prot,
  input  logic                alloc_wr_prot,
  output logic                alloc_done,
  output logic                alloc_ok,
  output logic [IDX_W-1:0]    alloc_slot
);
  localparam logic [IDX_W:0] SLOT_CNT = NUM_SLOTS[IDX_W:0];

  range_t [NUM_SLOTS-1:0] slots;
  range_t                 alloc_val;
  logic                   free_found;
  logic [IDX_W-1:0]       free_idx;
  logic [NUM_SLOTS-1:0]   hit;
  logic                   rd_block;
  logic                   wr_block;
  logic                   blocked;

  assign alloc_val.base  = alloc_start[FLASH_AW-1:GRAN_SHIFT];
  assign alloc_val.limit = page_t'(({1'b0, alloc_start} + alloc_size -
                                    (FLASH_AW+1)'(1)) >> GRAN_SHIFT);
  assign alloc_val.rd_en = alloc_rd_prot;
  assign alloc_val.wr_en = alloc_wr_prot;

  fprot_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_in    (lock_in),
    .wr_en      (reg_wr_en),
    .wr_idx     (reg_wr_idx),
    .wr_data    (reg_wr_data),
    .alloc_req  (alloc_req),
    .alloc_val  (alloc_val),
    .free_found (free_found),
    .free_idx   (free_idx),
    .slots      (slots),
    .alloc_done (alloc_done),
    .alloc_ok   (alloc_ok),
    .alloc_slot (alloc_slot)
  );

  fprot_free_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) pick_i (
    .slots (slots),
    .found (free_found),
    .idx   (free_idx)
  );

  fprot_range_match #(.NUM_SLOTS(NUM_SLOTS)) match_i (
    .slots    (slots),
    .addr     (lk_addr),
    .hit      (hit),
    .rd_block (rd_block),
    .wr_block (wr_block)
  );

  assign reg_rd_data = ({1'b0, reg_rd_idx} < SLOT_CNT) ? REG_W'(slots[reg_rd_idx]) : '0;
  assign blocked     = lk_is_write ? wr_block : rd_block;
  assign lk_allow    = lk_valid && !blocked;
  assign lk_deny     = lk_valid && blocked;

  // R8: the picker only offers a slot that is really empty
  assert_free_slot_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_found |-> (slots[free_idx] == '0));

  // R5: a denial always comes from at least one matching range
  assert_deny_has_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_deny |-> (hit != '0));
endmodule

// File: tb/fprot_range_guard_tb_top.sv
module fprot_range_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_in = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_idx = '0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_idx = '0;
  logic [31:0] reg_rd_data;
  logic        lk_valid = 1'b0;
  logic [26:0] lk_addr = '0;
  logic        lk_is_write = 1'b0;
  logic        lk_allow, lk_deny;
  logic        alloc_req = 1'b0;
  logic [26:0] alloc_start = '0;
  logic [27:0] alloc_size = '0;
  logic        alloc_rd_prot = 1'b0;
  logic        alloc_wr_prot = 1'b0;
  logic        alloc_done, alloc_ok;
  logic [2:0]  alloc_slot;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  fprot_range_guard dut_i (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_is_write(lk_is_write),
    .lk_allow(lk_allow), .lk_deny(lk_deny),
    .alloc_req(alloc_req), .alloc_start(alloc_start), .alloc_size(alloc_size),
    .alloc_rd_prot(alloc_rd_prot), .alloc_wr_prot(alloc_wr_prot),
    .alloc_done(alloc_done), .alloc_ok(alloc_ok), .alloc_slot(alloc_slot)
  );

  function automatic logic [31:0] enc(input int b, input int l, input bit r, input bit w);
    logic [31:0] bv, lv;
    bv = b;
    lv = l;
    return {w, lv[14:0], r, bv[14:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_rd_idx = idx; #1;
    d = reg_rd_data;
  endtask

  task automatic look(input logic [26:0] a, input bit w, output logic [1:0] res);
    lk_valid = 1'b1; lk_addr = a; lk_is_write = w; #1;
    res = {lk_allow, lk_deny};
    lk_valid = 1'b0; #1;
  endtask

  task automatic alloc(input logic [26:0] s, input logic [27:0] sz, input bit r, input bit w,
                       output logic [4:0] res);
    alloc_req = 1'b1; alloc_start = s; alloc_size = sz;
    alloc_rd_prot = r; alloc_wr_prot = w;
    @(posedge clk); #1;
    alloc_req = 1'b0;
    res = {alloc_done, alloc_ok, alloc_slot};
  endtask

  task automatic clear_all();
    for (int i = 0; i < 5; i++) wr(3'(i), 32'h0);
  endtask

  localparam logic [1:0] ALLOW = 2'b10, DENY = 2'b01;

  task automatic t_reset();
    logic [31:0] d; logic [1:0] r;
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), d);
      chk("R1 reset reg zero", d, 0);
    end
    chk("R1 reset alloc_done low", {31'b0, alloc_done}, 0);
    look(27'h0, 1'b1, r);
    chk("R1 reset write allowed", {30'b0, r}, {30'b0, ALLOW});
  endtask

  task automatic t_regport();
    logic [31:0] d; logic [1:0] r;
    wr(3'd2, enc(16'h10, 16'h1F, 1, 0));
    rd(3'd2, d);
    chk("R2 readback", d, enc(16'h10, 16'h1F, 1, 0));
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d);
    chk("R2 out-of-range read zero", d, 0);
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), d);
      chk("R2 out-of-range write ignored", d, (i == 2) ? enc(16'h10, 16'h1F, 1, 0) : 0);
    end
    look(27'h0FFFF, 0, r); chk("R3 below base", {30'b0, r}, {30'b0, ALLOW});
    look(27'h10000, 0, r); chk("R3 base inclusive", {30'b0, r}, {30'b0, DENY});
    look(27'h1FFFF, 0, r); chk("R3 limit inclusive", {30'b0, r}, {30'b0, DENY});
    look(27'h20000, 0, r); chk("R3 above limit", {30'b0, r}, {30'b0, ALLOW});
    look(27'h15000, 1, r); chk("R4 write not blocked by rd bit", {30'b0, r}, {30'b0, ALLOW});
    lk_valid = 0; lk_addr = 27'h15000; lk_is_write = 0; #1;
    chk("R6 idle outputs low", {30'b0, lk_allow, lk_deny}, 0);
    clear_all();
  endtask

  task automatic t_overlap();
    logic [1:0] r;
    wr(3'd2, enc(16'h10, 16'h1F, 1, 0));
    wr(3'd0, enc(16'h18, 16'h30, 0, 1));
    look(27'h19000, 1, r); chk("R4 write denied by wr bit", {30'b0, r}, {30'b0, DENY});
    look(27'h19000, 0, r); chk("R5 overlap read denied", {30'b0, r}, {30'b0, DENY});
    look(27'h25000, 0, r); chk("R4 read not blocked by wr bit", {30'b0, r}, {30'b0, ALLOW});
    look(27'h25000, 1, r); chk("R5 single match write denied", {30'b0, r}, {30'b0, DENY});
    look(27'h40000, 1, r); chk("R5 no match allowed", {30'b0, r}, {30'b0, ALLOW});
    clear_all();
  endtask

  task automatic t_alloc();
    logic [31:0] d; logic [4:0] a;
    wr(3'd0, enc(1, 1, 0, 1));
    alloc(27'h40000, 28'h2000, 1, 1, a);
    chk("R7 alloc result", {27'b0, a}, {27'b0, 1'b1, 1'b1, 3'd1});
    rd(3'd1, d);
    chk("R7 alloc encoding", d, enc(16'h40, 16'h41, 1, 1));
    @(posedge clk); #1;
    chk("R7 done is a pulse", {31'b0, alloc_done}, 0);
    wr(3'd0, 32'h0);
    alloc(27'h05100, 28'h100, 0, 1, a);
    chk("R12 freed slot reused", {27'b0, a}, {27'b0, 1'b1, 1'b1, 3'd0});
    rd(3'd0, d);
    chk("R7 unaligned encoding", d, enc(5, 5, 0, 1));
    clear_all();
  endtask

  task automatic t_full();
    logic [31:0] d; logic [4:0] a;
    for (int i = 0; i < 5; i++) wr(3'(i), enc(i, i, 0, 1));
    alloc(27'h80000, 28'h1000, 1, 0, a);
    chk("R8 full alloc fails", {27'b0, a}, {27'b0, 1'b1, 1'b0, 3'd0});
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), d);
      chk("R8 registers unchanged", d, enc(i, i, 0, 1));
    end
    clear_all();
  endtask

  task automatic t_noprot();
    logic [31:0] d; logic [4:0] a;
    alloc(27'h80000, 28'h1000, 0, 0, a);
    chk("R9 no-protect alloc fails", {27'b0, a}, {27'b0, 1'b1, 1'b0, 3'd0});
    rd(3'd0, d);
    chk("R9 nothing written", d, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    reg_wr_en = 1; reg_wr_idx = 3'd1; reg_wr_data = enc(7, 8, 1, 0);
    alloc_req = 1; alloc_start = 27'h80000; alloc_size = 28'h1000;
    alloc_rd_prot = 1; alloc_wr_prot = 1;
    @(posedge clk); #1;
    reg_wr_en = 0; alloc_req = 0;
    chk("R11 alloc fails on collision", {30'b0, alloc_done, alloc_ok}, 32'h2);
    rd(3'd1, d); chk("R11 port write taken", d, enc(7, 8, 1, 0));
    rd(3'd0, d); chk("R11 alloc wrote nothing", d, 0);
    clear_all();
  endtask

  task automatic t_lock();
    logic [31:0] d; logic [1:0] r; logic [4:0] a;
    wr(3'd0, enc(2, 2, 1, 1));
    lock_in = 1; reg_wr_en = 1; reg_wr_idx = 3'd3; reg_wr_data = enc(9, 9, 1, 1);
    @(posedge clk); #1;
    lock_in = 0; reg_wr_en = 0;
    rd(3'd3, d); chk("R10 same-cycle write ignored", d, 0);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R10 later write ignored", d, enc(2, 2, 1, 1));
    alloc(27'h80000, 28'h1000, 1, 1, a);
    chk("R10 alloc fails when locked", {27'b0, a}, {27'b0, 1'b1, 1'b0, 3'd0});
    rd(3'd1, d); chk("R10 alloc wrote nothing", d, 0);
    look(27'h2800, 0, r); chk("R10 lookup still enforced", {30'b0, r}, {30'b0, DENY});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_regport();
    t_overlap();
    t_alloc();
    t_full();
    t_noprot();
    t_collide();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule